// File: doc/BRIEF.md
# Second-Order Delta-Sigma Bitstream Generator

This block is a fully digital second-order delta-sigma modulator. Each bit period it takes a 16-bit offset-binary code and emits one bit, so that over time the fraction of ones in the stream equals code/65536. Midscale (32768) stands for a zero differential input. The stream is meant to feed a third-order sinc decimator. At a decimation rate of 256 that filter rebuilds 16-bit words at roughly 39 kSPS when the bit rate is 10 MHz.

The block divides its system clock by an even factor to make a free-running bit clock. It launches each data bit in the system cycle in which that clock rises, so the bit is steady when a receiver samples it on the following falling edge. A new code may be loaded at any time. It is held and only takes effect at the next bit boundary. The loop has two cascaded saturating integrators, and a single-bit quantizer feeds back into both of them. The two end codes bypass the loop and force a constant stream.

Top module: `sd2_bitstream_gen`

## Requirements
- R1: While `rst` is high, `mclkout` and `mdat` are low, the pending and active codes return to midscale (32768), and both integrators return to their start values.
- R2: `mclkout` repeats every `CLK_DIV` system cycles. It is high for exactly `CLK_DIV/2` cycles and low for exactly `CLK_DIV/2` cycles, which gives a 50% duty cycle.
- R3: `mdat` changes only in the system cycle in which `mclkout` rises. It stays unchanged across the following falling edge.
- R4: With code 32768 active from the integrator start state, the stream is exactly 1,0,1,0,..., and the first bit is 1.
- R5: For codes between 7168 and 58368, the number of ones in any run of 4096 consecutive bits is within ±3 of code×4096/65536. Code 58368 therefore gives a density of about 89.06% and code 7168 about 10.94%.
- R6: Code 65535 gives a constant stream of ones and code 0 gives a constant stream of zeros. While either code is active, both integrators are held at their start values.
- R7: A code presented with `code_ld` high is held. It first governs the bit launched at the next rise of `mclkout`, and the bit already on `mdat` is not disturbed before that rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | CODE_W | Offset-binary input code |
| code_ld | input | 1 | Load strobe for `code_in` |
| mclkout | output | 1 | Generated bit clock, system clock divided by CLK_DIV |
| mdat | output | 1 | Modulator bit, launched on the rise of `mclkout` |

## Verification
The bound checker watches every cycle for four things: `mdat` changing away from a rise of `mclkout`, high and low phases of the wrong length, the active code changing outside a bit boundary, and an end code giving any bit other than its forced value. Only the bench's directed scenarios can show the statistical behaviour. These cover the ones counts over long windows for several codes, the exact alternation at midscale, and the point at which a code loaded mid-bit first appears in the stream.

// File: rtl/sd2_pkg.sv
package sd2_pkg;

    parameter int unsigned SD2_CODE_W_DEF = 16;
    parameter int unsigned SD2_INT_W_DEF  = 20;
    parameter int unsigned SD2_DIV_DEF    = 10;

    // Where the quantizer decision comes from for one bit
    typedef enum logic [1:0] {
        QSEL_LOOP     = 2'd0,
        QSEL_FORCE_HI = 2'd1,
        QSEL_FORCE_LO = 2'd2
    } qsel_e;

endpackage

// File: rtl/sd2_clkdiv.sv
module sd2_clkdiv #(
    parameter int unsigned CLK_DIV = 10
) (
    input  logic clk,
    input  logic rst,
    output logic mclk,
    output logic bit_tick
);

    localparam int unsigned CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int unsigned HALF  = CLK_DIV / 2;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mclk;
    } div_st_t;

    localparam div_st_t DIV_RST = '{cnt: CNT_LAST, mclk: 1'b0};

    div_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.cnt == CNT_LAST) begin
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
        nxt_d.mclk = (nxt_d.cnt < CNT_HALF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= DIV_RST;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mclk     = cur_q.mclk;
    assign bit_tick = (cur_q.cnt == CNT_LAST);

endmodule

// File: rtl/sd2_loop.sv
module sd2_loop
    import sd2_pkg::*;
#(
    parameter int unsigned CODE_W = 16,
    parameter int unsigned INT_W  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              bit_o
);

    localparam int unsigned W2 = INT_W + 2;
    localparam logic signed [W2-1:0] FS_HALF = W2'(1) << (CODE_W - 1);
    localparam logic signed [W2-1:0] SAT_MAX = {3'b000, {(INT_W-1){1'b1}}};
    localparam logic signed [W2-1:0] SAT_MIN = {3'b111, {(INT_W-1){1'b0}}};

    typedef struct packed {
        logic signed [INT_W-1:0] i1;
        logic signed [INT_W-1:0] i2;
    } loop_st_t;

    // First integrator starts at a quarter of full scale so midscale alternates at once
    localparam loop_st_t LOOP_RST = '{i1: INT_W'(1) << (CODE_W - 2), i2: '0};

    loop_st_t cur_q, nxt_d;

    qsel_e                qsel;
    logic                 y;
    logic signed [W2-1:0] x_w, v_w, i1_x, i2_x, i1_nx;
    logic signed [INT_W-1:0] i1_n, i2_n;

    function automatic logic signed [INT_W-1:0] sat(input logic signed [W2-1:0] a);
        logic signed [INT_W-1:0] r;
        if (a > SAT_MAX) begin
            r = {1'b0, {(INT_W-1){1'b1}}};
        end else if (a < SAT_MIN) begin
            r = {1'b1, {(INT_W-1){1'b0}}};
        end else begin
            r = a[INT_W-1:0];
        end
        return r;
    endfunction

    always_comb begin
        if (code == '1) begin
            qsel = QSEL_FORCE_HI;
        end else if (code == '0) begin
            qsel = QSEL_FORCE_LO;
        end else begin
            qsel = QSEL_LOOP;
        end

        case (qsel)
            QSEL_FORCE_HI: y = 1'b1;
            QSEL_FORCE_LO: y = 1'b0;
            default:       y = ~cur_q.i2[INT_W-1];
        endcase

        x_w   = $signed(W2'(code)) - FS_HALF;
        v_w   = y ? FS_HALF : -FS_HALF;
        i1_x  = {{2{cur_q.i1[INT_W-1]}}, cur_q.i1};
        i2_x  = {{2{cur_q.i2[INT_W-1]}}, cur_q.i2};
        i1_n  = sat(i1_x + x_w - v_w);
        i1_nx = {{2{i1_n[INT_W-1]}}, i1_n};
        i2_n  = sat(i2_x + i1_nx - v_w);

        nxt_d = cur_q;
        if (tick) begin
            if (qsel != QSEL_LOOP) begin
                nxt_d = LOOP_RST;
            end else begin
                nxt_d.i1 = i1_n;
                nxt_d.i2 = i2_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= LOOP_RST;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign bit_o = y;

endmodule

// File: rtl/sd2_bitstream_gen.sv
module sd2_bitstream_gen
    import sd2_pkg::*;
#(
    parameter int unsigned CODE_W  = SD2_CODE_W_DEF,
    parameter int unsigned INT_W   = SD2_INT_W_DEF,
    parameter int unsigned CLK_DIV = SD2_DIV_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    input  logic              code_ld,
    output logic              mclkout,
    output logic              mdat
);

    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    typedef struct packed {
        logic [CODE_W-1:0] hold;
        logic [CODE_W-1:0] act;
        logic              mdat;
    } top_st_t;

    localparam top_st_t TOP_RST = '{hold: MID_CODE, act: MID_CODE, mdat: 1'b0};

    top_st_t           cur_q, nxt_d;
    logic              bit_tick;
    logic              mclk_w;
    logic              q_bit;
    logic [CODE_W-1:0] code_next;
    logic [CODE_W-1:0] code_act_q;

    sd2_clkdiv #(
        .CLK_DIV (CLK_DIV)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .mclk     (mclk_w),
        .bit_tick (bit_tick)
    );

    sd2_loop #(
        .CODE_W (CODE_W),
        .INT_W  (INT_W)
    ) u_loop (
        .clk   (clk),
        .rst   (rst),
        .tick  (bit_tick),
        .code  (code_next),
        .bit_o (q_bit)
    );

    always_comb begin
        code_next = code_ld ? code_in : cur_q.hold;
        nxt_d      = cur_q;
        nxt_d.hold = code_next;
        if (bit_tick) begin
            nxt_d.act  = code_next;
            nxt_d.mdat = q_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= TOP_RST;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign code_act_q = cur_q.act;
    assign mclkout    = mclk_w;
    assign mdat       = cur_q.mdat;

endmodule

// File: rtl/sd2_bitstream_gen_chk.sv
module sd2_bitstream_gen_chk #(
    parameter int unsigned CODE_W  = 16,
    parameter int unsigned CLK_DIV = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              mclkout,
    input logic              mdat,
    input logic              tick,
    input logic [CODE_W-1:0] code_act
);

    localparam logic [15:0] HALF = 16'(CLK_DIV / 2);

    logic [15:0] hi_run, lo_run;
    logic        seen_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run    <= '0;
            lo_run    <= '0;
            seen_fall <= 1'b0;
        end else begin
            hi_run <= mclkout ? hi_run + 1'b1 : '0;
            lo_run <= mclkout ? '0 : lo_run + 1'b1;
            if (!mclkout && hi_run != '0) begin
                seen_fall <= 1'b1;
            end
        end
    end

    AST_MDAT_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdat) |-> $rose(mclkout)); // R3

    AST_MCLK_HIGH_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(mclkout) |-> (hi_run == HALF)); // R2

    AST_MCLK_LOW_LEN: assert property (@(posedge clk) disable iff (rst)
        ($rose(mclkout) && seen_fall) |-> (lo_run == HALF)); // R2

    AST_CODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_act) |-> $past(tick)); // R7

    AST_ZERO_CODE_LOW: assert property (@(posedge clk) disable iff (rst)
        ($rose(mclkout) && code_act == '0) |-> !mdat); // R6

    AST_FULL_CODE_HIGH: assert property (@(posedge clk) disable iff (rst)
        ($rose(mclkout) && code_act == '1) |-> mdat); // R6

endmodule

bind sd2_bitstream_gen sd2_bitstream_gen_chk #(
    .CODE_W  (CODE_W),
    .CLK_DIV (CLK_DIV)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mclkout  (mclkout),
    .mdat     (mdat),
    .tick     (bit_tick),
    .code_act (code_act_q)
);

// File: tb/tb_sd2_bitstream_gen.sv
`timescale 1ns/1ps
module tb_sd2_bitstream_gen;

    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;
    localparam int WIN  = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] code_in = 16'h8000;
    logic        code_ld = 1'b0;
    logic        mclkout, mdat;

    int checks = 0;
    int errs   = 0;
    int bits = 0, ones = 0, align_err = 0, duty_err = 0, cyc = 0;
    int hi_run = 0, lo_run = 0;
    logic prev_m = 1'b0, prev_d = 1'b0, mon_ok = 1'b0, seen_fall = 1'b0;
    logic last_bit = 1'b0, rise;

    always #2 clk = ~clk;

    sd2_bitstream_gen #(.CLK_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .code_in(code_in), .code_ld(code_ld),
        .mclkout(mclkout), .mdat(mdat)
    );

    always @(posedge clk) cyc++;

    // Monitor: samples away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            prev_m = 1'b0; prev_d = 1'b0; mon_ok = 1'b0;
            hi_run = 0; lo_run = 0; seen_fall = 1'b0;
        end else begin
            rise = mclkout && !prev_m;
            if (mon_ok && (mdat !== prev_d) && !rise) align_err++;
            if (rise) begin
                bits++;
                if (mdat) ones++;
                last_bit = mdat;
                if (seen_fall && lo_run != HALF) duty_err++;
                lo_run = 0;
            end
            if (mclkout) hi_run++;
            else begin
                if (prev_m) begin
                    if (hi_run != HALF) duty_err++;
                    hi_run = 0;
                    seen_fall = 1'b1;
                end
                lo_run++;
            end
            prev_m = mclkout; prev_d = mdat; mon_ok = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic get_bit(output logic b);
        int t = bits;
        while (bits == t) @(posedge clk);
        b = last_bit;
    endtask

    task automatic load(input logic [15:0] c);
        @(negedge clk); code_in = c; code_ld = 1'b1;
        @(negedge clk); code_ld = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1; code_ld = 1'b0;
        repeat (3) @(negedge clk);
        chk(mdat == 1'b0, "R1 mdat low in reset", mdat, 0);
        chk(mclkout == 1'b0, "R1 mclkout low in reset", mclkout, 0);
        rst = 1'b0;
    endtask

    task automatic t_midscale;
        logic b;
        t_reset();
        for (int i = 0; i < 16; i++) begin
            get_bit(b);
            chk(b == ((i % 2) == 0), "R4 midscale alternation", b, (i % 2) == 0);
        end
    endtask

    task automatic t_rate;
        logic b;
        int c0;
        get_bit(b);
        c0 = cyc;
        for (int i = 0; i < 100; i++) get_bit(b);
        chk(cyc - c0 == 100 * DIV, "R2 bit period", cyc - c0, 100 * DIV);
    endtask

    task automatic t_density(input logic [15:0] c);
        logic b;
        int s, n, expv;
        t_reset();
        load(c);
        get_bit(b); get_bit(b);
        s = ones;
        for (int i = 0; i < WIN; i++) get_bit(b);
        n = ones - s;
        expv = int'(c) / 16;
        chk((n >= expv - 3) && (n <= expv + 3), "R5 ones count", n, expv);
    endtask

    task automatic t_extremes;
        logic b;
        int s;
        t_reset();
        load(16'hFFFF);
        get_bit(b);
        s = ones;
        for (int i = 0; i < 256; i++) get_bit(b);
        chk(ones - s == 256, "R6 full code all ones", ones - s, 256);
        load(16'h0000);
        get_bit(b);
        s = ones;
        for (int i = 0; i < 256; i++) get_bit(b);
        chk(ones - s == 0, "R6 zero code all zeros", ones - s, 0);
        // integrators held at start values: midscale restarts with 1,0,1,0
        load(16'h8000);
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            chk(b == ((i % 2) == 0), "R6 restart after clamp", b, (i % 2) == 0);
        end
    endtask

    task automatic t_load_timing;
        logic b;
        t_reset();
        get_bit(b);
        get_bit(b);  // second bit of alternation is 0
        chk(b == 1'b0, "R4 second bit", b, 0);
        @(negedge clk); code_in = 16'hFFFF; code_ld = 1'b1;
        @(negedge clk); code_ld = 1'b0;
        @(negedge clk);
        chk(mdat == 1'b0, "R7 bit held until rise", mdat, 0);
        get_bit(b);
        chk(b == 1'b1, "R7 new code at next rise", b, 1);
    endtask

    initial begin
        t_midscale();
        t_rate();
        t_load_timing();
        t_extremes();
        t_density(16'd32768);
        t_density(16'd58368);
        t_density(16'd7168);
        t_density(16'd16384);
        t_density(16'd49152);
        t_reset();
        chk(align_err == 0, "R3 mdat changed off rise", align_err, 0);
        chk(duty_err == 0, "R2 phase length", duty_err, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(190000 * 4);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule